// File: doc/BRIEF.md
# Deferred Program-Memory Bank Selector

This block extends the 11-bit program counter of a small 8-bit controller to 12 bits, so that code can sit in two 2 KiB banks. Two dedicated opcodes write a pending bank bit. That bit does not move the program counter when it is written. It is copied into PC bit 11 only when the next jump or call executes. Sequential fetches stay inside the current bank.

A third opcode sets a gate-enable flag. Only a synchronous reset clears this flag. Code that never issues any of the three opcodes runs in bank 0 and behaves exactly like code on the plain 11-bit counter.

The instruction side is a stream of beats qualified by `in_valid`. The block accepts every valid beat in the cycle it is presented, so there is no back-pressure and no ready signal. A cycle without `in_valid` changes no state. The return-address output is combinational and is qualified by `push_valid`. Control flags (`is_jump`, `is_call`, `is_ret`) count only while `in_valid` is high. A return has priority over a jump or call in the same beat.

Top module: `pmb_pc_ctrl`

## Requirements
- R1: After synchronous reset `pc` is 000h, `bank_sel` is 0 and `gate_en` is 0.
- R2: A valid beat with `op_byte` = 63h sets `bank_sel` to 0, and a valid beat with `op_byte` = 73h sets `bank_sel` to 1, in the next cycle. Neither opcode changes `pc[11]` during sequential fetches.
- R3: A valid beat with no control flag advances `pc` by one in bits 10:0, wrapping from 7FFh to 000h and from FFFh to 800h. Bit 11 is never carried into.
- R4: A valid jump or call beat, without a return, loads `pc` with {bank_sel, `tgt_addr`} in the next cycle.
- R5: When a bank opcode and a jump or call share a beat, the jump uses the `bank_sel` value held before that beat. The new bank value appears in the next cycle.
- R6: During a valid call beat, `push_valid` is 1 and `push_addr` equals {pc[11], pc[10:0]+1}, wrapped within the bank. At all other times `push_valid` is 0.
- R7: A valid return beat loads all 12 bits of `pc` from `ret_addr` and leaves `bank_sel` unchanged.
- R8: A valid beat with `op_byte` = 33h sets `gate_en`. The flag stays 1 through any later beats and clears only on reset.
- R9: A cycle with `in_valid` low leaves `pc`, `bank_sel` and `gate_en` unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the beat on all other inputs |
| op_byte | input | 8 | Fetched opcode byte |
| is_jump | input | 1 | Beat executes a jump |
| is_call | input | 1 | Beat executes a call |
| is_ret | input | 1 | Beat executes a return |
| tgt_addr | input | 11 | In-bank jump or call target |
| ret_addr | input | 12 | Return address popped from the stack |
| pc | output | 12 | Full program counter |
| bank_sel | output | 1 | Pending bank bit |
| gate_en | output | 1 | Sticky gate-enable flag |
| push_addr | output | 12 | Return address to push on a call |
| push_valid | output | 1 | `push_addr` is valid this cycle |

## Verification
The risky overlap is a bank-select opcode arriving in the same beat as a jump or call. The bench drives 63h or 73h together with a jump, after setting up the opposite pending value. It then checks that the new `pc[11]` takes the old pending bit, and that `bank_sel` shows the new value one cycle later. Sweeps over every target in both banks also cover the jump path. Walks across 7FFh and FFFh cover the wrap, and a call placed at FFFh checks that its return address wraps to 800h.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  localparam int PC_W  = 12;
  localparam int OFS_W = PC_W - 1;

  localparam logic [7:0] OP_BANK_LO = 8'h63;
  localparam logic [7:0] OP_BANK_HI = 8'h73;
  localparam logic [7:0] OP_GATE_ON = 8'h33;

  function automatic logic [PC_W-1:0] next_in_bank(input logic [PC_W-1:0] cur);
    logic [OFS_W-1:0] ofs;
    ofs = cur[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1};
    return {cur[PC_W-1], ofs};
  endfunction
endpackage

// File: rtl/pmb_opdec.sv
module pmb_opdec
  import pmb_pkg::*;
(
  input  logic       beat_ok,
  input  logic [7:0] opcode,
  output logic       want_lo,
  output logic       want_hi,
  output logic       want_gate
);
  always_comb begin
    want_lo   = beat_ok && (opcode == OP_BANK_LO);
    want_hi   = beat_ok && (opcode == OP_BANK_HI);
    want_gate = beat_ok && (opcode == OP_GATE_ON);
  end
endmodule

// File: rtl/pmb_state.sv
module pmb_state (
  input  logic clk,
  input  logic rst,
  input  logic want_lo,
  input  logic want_hi,
  input  logic want_gate,
  output logic bank_q,
  output logic gate_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      if (want_hi)      bank_q <= 1'b1;
      else if (want_lo) bank_q <= 1'b0;
      if (want_gate)    gate_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pmb_pcseq.sv
module pmb_pcseq
  import pmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_ok,
  input  logic             do_jump,
  input  logic             do_call,
  input  logic             do_ret,
  input  logic [OFS_W-1:0] target,
  input  logic [PC_W-1:0]  popped,
  input  logic             bank_cur,
  output logic [PC_W-1:0]  pc_q,
  output logic [PC_W-1:0]  link_addr,
  output logic             link_ok
);
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_nxt;

  always_comb begin
    pc_inc    = next_in_bank(pc_q);
    link_addr = pc_inc;
    link_ok   = beat_ok && do_call && !do_ret;
    pc_nxt    = pc_q;
    if (beat_ok) begin
      if (do_ret)                  pc_nxt = popped;
      else if (do_jump || do_call) pc_nxt = {bank_cur, target};
      else                         pc_nxt = pc_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end
endmodule

// File: rtl/pmb_pc_ctrl.sv
module pmb_pc_ctrl
  import pmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       op_byte,
  input  logic             is_jump,
  input  logic             is_call,
  input  logic             is_ret,
  input  logic [OFS_W-1:0] tgt_addr,
  input  logic [PC_W-1:0]  ret_addr,
  output logic [PC_W-1:0]  pc,
  output logic             bank_sel,
  output logic             gate_en,
  output logic [PC_W-1:0]  push_addr,
  output logic             push_valid
);
  logic want_lo, want_hi, want_gate;

  pmb_opdec u_dec (
    .beat_ok  (in_valid),
    .opcode   (op_byte),
    .want_lo  (want_lo),
    .want_hi  (want_hi),
    .want_gate(want_gate)
  );

  pmb_state u_state (
    .clk      (clk),
    .rst      (rst),
    .want_lo  (want_lo),
    .want_hi  (want_hi),
    .want_gate(want_gate),
    .bank_q   (bank_sel),
    .gate_q   (gate_en)
  );

  pmb_pcseq u_seq (
    .clk      (clk),
    .rst      (rst),
    .beat_ok  (in_valid),
    .do_jump  (is_jump),
    .do_call  (is_call),
    .do_ret   (is_ret),
    .target   (tgt_addr),
    .popped   (ret_addr),
    .bank_cur (bank_sel),
    .pc_q     (pc),
    .link_addr(push_addr),
    .link_ok  (push_valid)
  );
endmodule

// File: rtl/pmb_pc_ctrl_chk.sv
module pmb_pc_ctrl_chk
  import pmb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [7:0]       op_byte,
  input logic             is_jump,
  input logic             is_call,
  input logic             is_ret,
  input logic [PC_W-1:0]  ret_addr,
  input logic [PC_W-1:0]  pc,
  input logic             bank_sel,
  input logic             gate_en,
  input logic             push_valid
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (in_valid && !is_jump && !is_call && !is_ret) |=>
      (pc[PC_W-1] == $past(pc[PC_W-1]) && pc[OFS_W-1:0] == $past(pc[OFS_W-1:0]) + 1'b1)); // R3

  AST_JMP_OLD_BANK: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (in_valid && (is_jump || is_call) && !is_ret) |=> (pc[PC_W-1] == $past(bank_sel))); // R5

  AST_RET_LOAD: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (in_valid && is_ret) |=> (pc == $past(ret_addr))); // R7

  AST_RET_BANK_KEEP: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (in_valid && is_ret && op_byte != OP_BANK_LO && op_byte != OP_BANK_HI) |=> $stable(bank_sel)); // R7

  AST_GATE_STICKY: assert property (@(posedge clk) disable iff (rst || !past_ok)
    gate_en |=> gate_en); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !in_valid |=> ($stable(pc) && $stable(bank_sel) && $stable(gate_en))); // R9

  AST_PUSH_QUAL: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> (in_valid && is_call)); // R6
endmodule

bind pmb_pc_ctrl pmb_pc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_byte(op_byte),
  .is_jump(is_jump), .is_call(is_call), .is_ret(is_ret), .ret_addr(ret_addr),
  .pc(pc), .bank_sel(bank_sel), .gate_en(gate_en), .push_valid(push_valid)
);

// File: tb/pmb_pc_ctrl_tb_top.sv
module pmb_pc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  op_byte = 8'h00;
  logic        is_jump = 1'b0, is_call = 1'b0, is_ret = 1'b0;
  logic [10:0] tgt_addr = '0;
  logic [11:0] ret_addr = '0;
  logic [11:0] pc, push_addr;
  logic        bank_sel, gate_en, push_valid;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_pc;
  logic        m_bank, m_gate;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pmb_pc_ctrl dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_byte(op_byte),
    .is_jump(is_jump), .is_call(is_call), .is_ret(is_ret),
    .tgt_addr(tgt_addr), .ret_addr(ret_addr), .pc(pc), .bank_sel(bank_sel),
    .gate_en(gate_en), .push_addr(push_addr), .push_valid(push_valid)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%03h exp=%03h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " pc"}, pc, m_pc);
    chk({req, " bank"}, {11'd0, bank_sel}, {11'd0, m_bank});
    chk({req, " gate"}, {11'd0, gate_en}, {11'd0, m_gate});
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    m_pc = 12'h000; m_bank = 1'b0; m_gate = 1'b0;
  endtask

  // One beat: drive, check combinational push output, step model, check registers.
  task automatic beat(input logic v, input logic [7:0] op, input logic j, input logic c,
                      input logic r, input logic [10:0] t, input logic [11:0] ra,
                      input string req);
    logic [11:0] exp_push;
    in_valid = v; op_byte = op; is_jump = j; is_call = c; is_ret = r;
    tgt_addr = t; ret_addr = ra;
    #1;
    exp_push = {m_pc[11], 11'(m_pc[10:0] + 11'd1)};
    if (v && c && !r) begin
      chk("R6 push_valid", {11'd0, push_valid}, 12'd1);
      chk("R6 push_addr", push_addr, exp_push);
    end else begin
      chk("R6 push idle", {11'd0, push_valid}, 12'd0);
    end
    if (v) begin
      if (r)          m_pc = ra;
      else if (j | c) m_pc = {m_bank, t};
      else            m_pc = exp_push;
      if (op == 8'h73)      m_bank = 1'b1;
      else if (op == 8'h63) m_bank = 1'b0;
      if (op == 8'h33)      m_gate = 1'b1;
    end
    @(posedge clk); #1;
    chk_state(req);
  endtask

  task automatic fetch(input string req);
    beat(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 11'd0, 12'd0, req);
  endtask

  initial begin
    #1;
    do_reset();
    chk_state("R1 reset");

    // R3: full sweep of bank 0 across the 7FFh wrap
    for (int i = 0; i < 2049; i++) fetch("R3 seq bank0");
    chk("R3 wrap to 000", pc, 12'h001);

    // R2: bank-high opcode is deferred
    beat(1'b1, 8'h73, 1'b0, 1'b0, 1'b0, 11'd0, 12'd0, "R2 sel hi");
    for (int i = 0; i < 4; i++) fetch("R2 pc11 held");
    chk("R2 pc11 still 0", {11'd0, pc[11]}, 12'd0);

    // R4: jump into bank 1
    beat(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 11'h123, 12'd0, "R4 jump");
    chk("R4 jump value", pc, 12'h923);

    // R3: wrap FFFh -> 800h
    beat(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 11'h7FE, 12'd0, "R4 jump 7FE");
    fetch("R3 to FFF");
    fetch("R3 wrap");
    chk("R3 wrap to 800", pc, 12'h800);

    // R6: call at FFFh pushes 800h
    beat(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 11'h7FF, 12'd0, "R4 jump 7FF");
    beat(1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 11'h055, 12'd0, "R6 call FFF");
    chk("R6 call dest", pc, 12'h855);

    // R5: same-beat select and jump uses old bank
    beat(1'b1, 8'h63, 1'b1, 1'b0, 1'b0, 11'h200, 12'd0, "R5 lo+jump");
    chk("R5 old bank hi", pc, 12'hA00);
    beat(1'b1, 8'h73, 1'b0, 1'b1, 1'b0, 11'h201, 12'd0, "R5 hi+call");
    chk("R5 old bank lo", pc, 12'h201);

    // R7: return restores 12 bits, bank untouched
    beat(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 11'd0, 12'h456, "R7 ret");
    chk("R7 bank kept", {11'd0, bank_sel}, 12'd1);
    beat(1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 11'h333, 12'hFED, "R7 ret prio");

    // R9: invalid beats ignored
    for (int i = 0; i < 8; i++)
      beat(1'b0, (i % 2 == 0) ? 8'h63 : 8'h33, 1'b1, 1'(i % 2), 1'(i / 4), 11'(i * 37), 12'(i * 501), "R9 idle");
    chk("R9 pc", pc, 12'hFED);

    // R8: gate flag sticky across traffic
    beat(1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 11'd0, 12'd0, "R8 gate on");
    for (int op = 0; op < 256; op++)
      beat(1'b1, 8'(op), 1'(op % 3 == 0), 1'(op % 5 == 0), 1'(op % 7 == 0), 11'(op * 9), 12'(op * 17), "R8 gate held");
    chk("R8 gate still set", {11'd0, gate_en}, 12'd1);

    // R4: target sweep in both banks
    for (int b = 0; b < 2; b++) begin
      beat(1'b1, b ? 8'h73 : 8'h63, 1'b0, 1'b0, 1'b0, 11'd0, 12'd0, "R2 sel");
      for (int t = 0; t < 2048; t++)
        beat(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 11'(t), 12'd0, "R4 sweep");
    end

    do_reset();
    chk_state("R1 reset clears gate");
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule